// File: doc/BRIEF.md
# GHASH Key Power Table Builder

This block turns a 128-bit GHASH hash subkey into the key material that a wide-aggregation GHASH engine reads. On a start strobe it samples the key and converts it into a bit-reflected "twisted" form. It then forms the second, third and fourth powers of that value in GF(2^128). Each power comes from one pass through a Karatsuba carry-less multiplier followed by a two-stage Montgomery-style fold. For each pair of powers the block also keeps the XOR of their high and low 64-bit halves. That packed half-sum is the middle-product operand the engine's Karatsuba multiplier needs.

The six table words are held in registers. Any number of combinational read ports can read them by slot index. A client pulses start, waits for the done flag, and then reads the table while the block sits idle. The table contents are undefined for reading while busy is high. The block does not derive the subkey from a cipher.

Top module: `ghpc_top`

## Requirements
- R1: After reset, busy and done are low and every read port returns zero for every index 0 to 7.
- R2: A start pulse sampled while busy is low makes busy high from the next cycle for exactly three cycles. Busy and done are never high together. Done then rises and stays high until the next accepted start, which drops it.
- R3: Slot 0 holds the twisted key. To form it, swap the key's two 64-bit halves, shift the 128-bit result left by one bit with a zero fill, and, if the bit shifted out was 1, XOR in a constant whose top byte is 0xC2 and whose bit 0 is 1.
- R4: The block multiplies with M(a,b) = a*b*x^-128 mod (x^128+x^127+x^126+x^121+1), where bit i of a word is the coefficient of x^i. Slot 2 holds M(h,h), with h the twisted key.
- R5: Slot 3 holds M(h, slot 2) and slot 5 holds M(slot 2, slot 2).
- R6: Slot 1 packs half-sums, where a half-sum is bits 127:64 XOR bits 63:0 of a word. Bits 63:0 take the half-sum of slot 0 and bits 127:64 take that of slot 2.
- R7: Slot 4 packs half-sums. Bits 63:0 take the half-sum of slot 3 and bits 127:64 take that of slot 5.
- R8: A start pulse sampled while busy is high is ignored. Neither the key sampled at the accepted start nor the busy/done timing changes.
- R9: Read indices 6 and 7 return zero, and every read port decodes its own index independently in the same cycle.
- R10: While the block is not busy and start is low, the table contents do not change, even if the key input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe, sampled when not busy |
| key_i | input | 128 | Hash subkey |
| busy_o | output | 1 | Power computation in progress |
| done_o | output | 1 | Table complete and readable |
| rd_idx_i | input | RD_PORTS*3 | Slot index per read port, port p in bits 3p+2:3p |
| rd_data_o | output | RD_PORTS*128 | Slot contents per read port, port p in bits 128p+127:128p |

## Verification
The embedded assertions assume that start arrives synchronous to the clock and that the key is valid in the cycle start is sampled. They do not assume the key stays stable after that cycle. The hold-on-idle and ignore-while-busy properties depend on this. The stimulus drives start and the key only at the falling edge, and it changes the key freely both during the busy window and while idle. This places those properties exactly on the cases they guard. Keys are chosen so that the twist carry both does and does not occur, along with an all-zero key and an all-ones key.

// File: rtl/ghpc_pkg.sv
package ghpc_pkg;
  localparam int unsigned BLK_W     = 128;
  localparam int unsigned HALF_W    = BLK_W / 2;
  localparam int unsigned NUM_SLOTS = 6;
  localparam int unsigned IDX_W     = 3;

  // Fold multiplier for the low word during reduction (x^63 + x^62 + x^57).
  localparam logic [HALF_W-1:0] FOLD_K  = 64'hC200_0000_0000_0000;
  // Correction applied when the twist shift carries out.
  localparam logic [BLK_W-1:0]  TWIST_K = {8'hC2, 119'd0, 1'b1};

  // Slot map: the engine that reads the table decodes these positions.
  localparam int unsigned SL_P1   = 0;
  localparam int unsigned SL_HS12 = 1;
  localparam int unsigned SL_P2   = 2;
  localparam int unsigned SL_P3   = 3;
  localparam int unsigned SL_HS34 = 4;
  localparam int unsigned SL_P4   = 5;

  typedef logic [BLK_W-1:0] blk_t;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_SQR,
    PS_CUB,
    PS_QUA,
    PS_DONE
  } pstate_e;

  function automatic logic [HALF_W-1:0] half_fold(input blk_t v);
    return v[BLK_W-1:HALF_W] ^ v[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/ghpc_clmul.sv
module ghpc_clmul #(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  localparam int unsigned PW = 2 * N;

  logic [PW-1:0] a_ext;
  assign a_ext = {{N{1'b0}}, a_i};

  always_comb begin
    p_o = '0;
    for (int i = 0; i < N; i++) begin
      if (b_i[i]) p_o = p_o ^ (a_ext << i);
    end
  end
endmodule

// File: rtl/ghpc_twist.sv
module ghpc_twist
  import ghpc_pkg::*;
#(
  parameter int unsigned W = BLK_W
) (
  input  logic [W-1:0] key_i,
  output logic [W-1:0] tw_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] swapped;
  logic [W-1:0] shifted;

  assign swapped = {key_i[H-1:0], key_i[W-1:H]};
  assign shifted = {swapped[W-2:0], 1'b0};
  assign tw_o    = swapped[W-1] ? (shifted ^ TWIST_K) : shifted;
endmodule

// File: rtl/ghpc_mulred.sv
module ghpc_mulred
  import ghpc_pkg::*;
#(
  parameter int unsigned W = BLK_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] r_o
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned NP = 3;  // Karatsuba: low, high, cross

  logic [H-1:0] opa [NP];
  logic [H-1:0] opb [NP];
  logic [W-1:0] pp  [NP];

  assign opa[0] = a_i[H-1:0];
  assign opb[0] = b_i[H-1:0];
  assign opa[1] = a_i[W-1:H];
  assign opb[1] = b_i[W-1:H];
  assign opa[2] = a_i[H-1:0] ^ a_i[W-1:H];
  assign opb[2] = b_i[H-1:0] ^ b_i[W-1:H];

  for (genvar g = 0; g < NP; g++) begin : g_part
    ghpc_clmul #(.N(H)) u_pp (
      .a_i(opa[g]),
      .b_i(opb[g]),
      .p_o(pp[g])
    );
  end

  // 256-bit product as four 64-bit words w0 (lowest) .. w3.
  logic [W-1:0] mid;
  logic [H-1:0] w0, w1, w2, w3;
  assign mid = pp[2] ^ pp[0] ^ pp[1];
  assign w0  = pp[0][H-1:0];
  assign w1  = pp[0][W-1:H] ^ mid[H-1:0];
  assign w2  = pp[1][H-1:0] ^ mid[W-1:H];
  assign w3  = pp[1][W-1:H];

  // Stage one folds w0 into w1/w2, stage two folds the updated w1 into w2/w3.
  logic [W-1:0] fold_a, fold_b;
  logic [H-1:0] w1_f;

  ghpc_clmul #(.N(H)) u_fold_a (
    .a_i(w0),
    .b_i(FOLD_K),
    .p_o(fold_a)
  );

  assign w1_f = w1 ^ fold_a[H-1:0];

  ghpc_clmul #(.N(H)) u_fold_b (
    .a_i(w1_f),
    .b_i(FOLD_K),
    .p_o(fold_b)
  );

  assign r_o = {w3 ^ w1_f ^ fold_b[W-1:H],
                w2 ^ w0 ^ fold_a[W-1:H] ^ fold_b[H-1:0]};
endmodule

// File: rtl/ghpc_table.sv
module ghpc_table
  import ghpc_pkg::*;
#(
  parameter int unsigned W        = BLK_W,
  parameter int unsigned SLOTS    = NUM_SLOTS,
  parameter int unsigned IDXW     = IDX_W,
  parameter int unsigned RD_PORTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         wr_en_i,
  input  logic [W-1:0]             wr_data_i [SLOTS],
  output logic [W-1:0]             mem_o     [SLOTS],
  input  logic [RD_PORTS*IDXW-1:0] rd_idx_i,
  output logic [RD_PORTS*W-1:0]    rd_data_o
);
  logic [W-1:0] mem_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mem_q[s] <= '0;
      else if (wr_en_i[s])   mem_q[s] <= wr_data_i[s];
    end
    assign mem_o[s] = mem_q[s];

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i[s] |=> $stable(mem_q[s])) else $error("slot changed without write"); // R10
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [IDXW-1:0] idx;
    logic [W-1:0]    data;
    assign idx = rd_idx_i[p*IDXW +: IDXW];
    always_comb begin
      data = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (idx == IDXW'(s)) data = mem_q[s];
      end
    end
    assign rd_data_o[p*W +: W] = data;
  end
endmodule

// File: rtl/ghpc_top.sv
module ghpc_top
  import ghpc_pkg::*;
#(
  parameter int unsigned W        = BLK_W,
  parameter int unsigned IDXW     = IDX_W,
  parameter int unsigned RD_PORTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [W-1:0]             key_i,
  output logic                     busy_o,
  output logic                     done_o,
  input  logic [RD_PORTS*IDXW-1:0] rd_idx_i,
  output logic [RD_PORTS*W-1:0]    rd_data_o
);
  localparam int unsigned SLOTS = NUM_SLOTS;

  pstate_e state_q, state_d;
  logic    accept;

  logic [W-1:0]     tw;
  logic [W-1:0]     op_a, op_b, prod;
  logic [SLOTS-1:0] wr_en;
  logic [W-1:0]     wr_data [SLOTS];
  logic [W-1:0]     tab     [SLOTS];

  assign busy_o = (state_q == PS_SQR) || (state_q == PS_CUB) || (state_q == PS_QUA);
  assign done_o = (state_q == PS_DONE);
  assign accept = start_i && !busy_o;

  // Next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE, PS_DONE: if (start_i) state_d = PS_SQR;
      PS_SQR:           state_d = PS_CUB;
      PS_CUB:           state_d = PS_QUA;
      PS_QUA:           state_d = PS_DONE;
      default:          state_d = PS_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  ghpc_twist #(.W(W)) u_twist (
    .key_i(key_i),
    .tw_o (tw)
  );

  // Operand selection for the shared multiply-reduce unit
  always_comb begin
    op_a = tab[SL_P1];
    op_b = tab[SL_P1];
    unique case (state_q)
      PS_CUB:  op_b = tab[SL_P2];
      PS_QUA:  begin
        op_a = tab[SL_P2];
        op_b = tab[SL_P2];
      end
      default: ;
    endcase
  end

  ghpc_mulred #(.W(W)) u_mulred (
    .a_i(op_a),
    .b_i(op_b),
    .r_o(prod)
  );

  // Write enables and data per slot
  always_comb begin
    wr_en            = '0;
    wr_en[SL_P1]     = accept;
    wr_en[SL_HS12]   = (state_q == PS_SQR);
    wr_en[SL_P2]     = (state_q == PS_SQR);
    wr_en[SL_P3]     = (state_q == PS_CUB);
    wr_en[SL_HS34]   = (state_q == PS_QUA);
    wr_en[SL_P4]     = (state_q == PS_QUA);
  end

  assign wr_data[SL_P1]   = tw;
  assign wr_data[SL_HS12] = {half_fold(prod), half_fold(tab[SL_P1])};
  assign wr_data[SL_P2]   = prod;
  assign wr_data[SL_P3]   = prod;
  assign wr_data[SL_HS34] = {half_fold(prod), half_fold(tab[SL_P3])};
  assign wr_data[SL_P4]   = prod;

  ghpc_table #(
    .W(W), .SLOTS(SLOTS), .IDXW(IDXW), .RD_PORTS(RD_PORTS)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .mem_o    (tab),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)) else $error("busy and done together"); // R2
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o)) else $error("start not launched"); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o) else $error("done dropped"); // R2
  AST_BUSY_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(tab[SL_P1])) else $error("twisted key rewritten while busy"); // R8
  AST_TWIST_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (tab[SL_P1][0] == $past(key_i[W/2-1]))) else $error("twist carry bit"); // R3
endmodule

// File: tb/tb_ghpc_top.sv
module tb_ghpc_top;
  localparam int CLK_P = 10;
  localparam int NP    = 2;
  localparam int IW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [127:0]     key_i = '0;
  logic             busy_o, done_o;
  logic [NP*IW-1:0] rd_idx_i = '0;
  logic [NP*128-1:0] rd_data_o;

  int vec_cnt = 0;
  int miss_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  ghpc_top #(.RD_PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
    .busy_o(busy_o), .done_o(done_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [127:0] ref_twist(input logic [127:0] k);
    logic [127:0] sw, t;
    sw = {k[63:0], k[127:64]};
    t  = sw << 1;
    if (sw[127]) t = t ^ {8'hC2, 119'd0, 1'b1};
    return t;
  endfunction

  // Bit-serial a*b*x^-128 mod P
  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 128; i++) begin
      if (b[i]) r = r ^ a;
      if (r[0]) r = (r >> 1) ^ {8'hE1, 120'd0};
      else      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [63:0] hs(input logic [127:0] v);
    return v[127:64] ^ v[63:0];
  endfunction

  logic [127:0] exp_tab [8];
  int           m_left;
  bit           m_done;

  task automatic load_expect(input logic [127:0] k);
    logic [127:0] h1, h2, h3, h4;
    h1 = ref_twist(k);
    h2 = ref_mul(h1, h1);
    h3 = ref_mul(h1, h2);
    h4 = ref_mul(h2, h2);
    exp_tab[0] = h1;
    exp_tab[1] = {hs(h2), hs(h1)};
    exp_tab[2] = h2;
    exp_tab[3] = h3;
    exp_tab[4] = {hs(h4), hs(h3)};
    exp_tab[5] = h4;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0;
      m_done = 1'b0;
      for (int i = 0; i < 8; i++) exp_tab[i] = '0;
    end else if (m_left > 0) begin
      m_left = m_left - 1;
      if (m_left == 0) m_done = 1'b1;
    end else if (start_i) begin
      m_left = 3;
      m_done = 1'b0;
      load_expect(key_i);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    vec_cnt++;
    if (!ok) begin
      miss_cnt++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle compare of the handshake (R2, R8 timing)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == (m_left > 0), "R2 busy", 128'(busy_o), 128'(m_left > 0));
      chk(done_o == m_done, "R2 done", 128'(done_o), 128'(m_done));
    end
  end

  // Read whole table on both ports (R3..R7, R9)
  task automatic check_table(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx_i = {IW'(7 - i), IW'(i)};
      #1;
      chk(rd_data_o[127:0] == exp_tab[i], $sformatf("%s p0 slot%0d", tag, i),
          rd_data_o[127:0], exp_tab[i]);
      chk(rd_data_o[255:128] == exp_tab[7 - i], $sformatf("%s p1 slot%0d", tag, 7 - i),
          rd_data_o[255:128], exp_tab[7 - i]);
    end
  endtask

  task automatic run_key(input logic [127:0] k, input string tag);
    @(negedge clk);
    key_i   = k;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    key_i   = ~k;
    repeat (4) @(negedge clk);
    check_table(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    miss_cnt++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 1'b0, "R1 busy", 128'(busy_o), 128'd0);
    chk(done_o == 1'b0, "R1 done", 128'(done_o), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_table("R1 reset");

    // R3 no carry, R4/R5/R6/R7 powers
    run_key(128'h1, "R3 R4 R5 R6 R7 unit");
    // R3 carry path: key bit 63 lands on top after the swap
    run_key(128'h0000_0000_0000_0000_8000_0000_0000_0000, "R3 carry");
    run_key({128{1'b1}}, "R4 ones");
    run_key(128'h66e9_4bd4_ef8a_2c3b_884c_fa59_ca34_2b2e, "R5 mix");
    run_key(128'h0, "R6 zero");
    run_key(128'hb83b_5337_08bf_535d_0aa6_e529_80d5_3b78, "R7 mix");

    // R8: second start while busy with a different key is ignored
    @(negedge clk);
    key_i   = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    start_i = 1'b1;
    @(negedge clk);
    key_i   = 128'hdead_beef_0000_1111_2222_3333_4444_5555;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    check_table("R8 ignore");

    // R10: idle with key toggling, table unchanged
    for (int c = 0; c < 6; c++) begin
      key_i = {4{32'(c * 32'h9e37_79b9)}};
      @(negedge clk);
    end
    check_table("R10 hold");

    // R9: out-of-range indices on both ports
    rd_idx_i = {IW'(6), IW'(7)};
    #1;
    chk(rd_data_o == '0, "R9 high idx", rd_data_o[127:0], 128'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end
endmodule